// File: doc/BRIEF.md
# Floating-Point Exception Control and Status Register

This block is the 32-bit exception control and status word of a floating-point unit. Each clock cycle it may receive one exception report from the arithmetic datapath, a strobe marking a finished operation plus a six-bit set of raised exceptions. The six exceptions are unimplemented operation, inexact, underflow, divide by zero, overflow and invalid operation. The block stores that set as the cause of the latest operation. It compares the set against per-exception trap enables and raises a one-cycle trap request when any enabled exception, or an unimplemented operation, occurred. Exceptions whose trap is masked are folded into sticky flags that software later inspects and clears.

Software sees the whole word through a plain write port and a continuously driven read value. The word also carries the denormal-handling bit and the two-bit rounding mode, which the datapath takes from dedicated outputs. Bit positions are given with bit 31 as the most significant bit. Unused positions always read as zero.

Top module: `fpu_exc_csr`

## Requirements
- R1: After synchronous reset the read value is 0x00000100: denormal bit (bit 8) is 1, every other bit is 0, trap_req is 0, rm is 0 and dn is 1.
- R2: Bits 25 down to 15 and bit 9 always read as 0; values written to them are discarded.
- R3: Sticky flags sit at bit 30 (inexact), 29 (underflow), 28 (divide by zero), 27 (overflow) and 26 (invalid). A flag becomes 1 in the cycle after a finished operation reports that exception while its enable is 0, and stays 1 until a software write puts 0 there.
- R4: Trap enables sit at bit 14 (inexact), 13 (underflow), 12 (divide by zero), 11 (overflow) and 10 (invalid). An exception whose enable is 1 sets no sticky flag. Enable values are taken as stored before the current cycle's write.
- R5: Bit 31 reads as the OR of the underflow, divide-by-zero, overflow and invalid flags; the inexact flag does not affect it.
- R6: Cause bits sit at bit 7 (unimplemented), 6 (inexact), 5 (underflow), 4 (divide by zero), 3 (overflow) and 2 (invalid). On a finished operation they are loaded with that operation's exception set, taking precedence over a same-cycle write to them; otherwise a write loads them.
- R7: When a software write and a finished operation fall in the same cycle, the written flag values are applied first and the operation's masked exceptions are then ORed in, so no event is lost.
- R8: trap_req is 1 in exactly the cycle after a finished operation that reported the unimplemented exception or any exception whose enable was 1. It is 0 in every other cycle, and exception inputs are ignored while op_done is 0.
- R9: Bits 1:0 hold the rounding mode and bit 8 the denormal bit; a write updates them and outputs rm and dn follow the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Datapath finished an operation this cycle |
| op_exc | input | 6 | Exceptions of that operation: [0] inexact, [1] underflow, [2] divide by zero, [3] overflow, [4] invalid, [5] unimplemented |
| rd_data | output | 32 | Current register value |
| trap_req | output | 1 | Registered trap request |
| rm | output | 2 | Rounding mode field |
| dn | output | 1 | Denormal handling bit |

## Verification
The assertions take op_exc to carry meaning only while op_done is 1. They also take the enables used for gating to be those stored before the cycle, so a write that changes an enable acts from the following operation on. The stimulus drives random exception patterns even while op_done is 0, which checks that they are ignored. It writes every bit of the word at random, reserved positions included, and mixes writes with finished operations in the same cycle so that the write-then-merge order is exercised.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CSR_W      = 32;
  localparam int NEXC       = 5;   // maskable exceptions
  localparam int RM_W       = 2;
  // LSB-0 positions
  localparam int POS_SUM    = 31;
  localparam int POS_FLAG   = 30;  // inexact flag, others follow downward
  localparam int POS_EN     = 14;  // inexact enable, others follow downward
  localparam int POS_DN     = 8;
  localparam int POS_CAUSE  = 7;   // unimplemented cause, then inexact downward
  localparam int POS_RM     = 0;
  localparam logic [CSR_W-1:0] RESET_VAL = 32'h0000_0100;
  // exception index order in vectors: 0 inexact, 1 underflow, 2 divzero,
  // 3 overflow, 4 invalid, NEXC unimplemented
  localparam int IDX_UNIMPL = NEXC;
endpackage

// File: rtl/fpx_sticky_bank.sv
module fpx_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wr_flags,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else
        flags[i] <= (wr_en ? wr_flags[i] : flags[i]) | set_vec[i];
    end

    // a set flag is kept while software leaves it alone
    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && flags[i]) |=> flags[i]);
    // a masked event is never lost, even against a clearing write
    assert_event_kept_R7: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags[i]);
  end
endmodule

// File: rtl/fpx_trap_gate.sv
module fpx_trap_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_done,
  input  logic [N:0]   op_exc,
  input  logic [N-1:0] enables,
  output logic [N-1:0] set_vec,
  output logic         trap_req
);
  logic trap_now;

  always_comb begin
    trap_now = 1'b0;
    set_vec  = '0;
    if (op_done) begin
      trap_now = op_exc[N] | (|(op_exc[N-1:0] & enables));
      set_vec  = op_exc[N-1:0] & ~enables;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= trap_now;
  end

  assert_trap_needs_op_R8: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(op_done));
  assert_unimpl_traps_R6: assert property (@(posedge clk) disable iff (rst)
    (op_done && op_exc[N]) |=> trap_req);
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (op_done && !op_exc[N] && ((op_exc[N-1:0] & enables) == '0)) |=> !trap_req);
endmodule

// File: rtl/fpx_ctrl_regs.sv
module fpx_ctrl_regs
  import fpx_pkg::*;
#(
  parameter int N = NEXC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [N-1:0]    wr_enables,
  input  logic [N:0]      wr_cause,
  input  logic            wr_dn,
  input  logic [RM_W-1:0] wr_rm,
  input  logic            op_done,
  input  logic [N:0]      op_exc,
  output logic [N-1:0]    enables,
  output logic [N:0]      cause,
  output logic            dn_q,
  output logic [RM_W-1:0] rm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enables <= '0;
      dn_q    <= RESET_VAL[POS_DN];
      rm_q    <= RESET_VAL[POS_RM +: RM_W];
    end else if (wr_en) begin
      enables <= wr_enables;
      dn_q    <= wr_dn;
      rm_q    <= wr_rm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cause <= '0;
    else if (op_done) cause <= op_exc;
    else if (wr_en)   cause <= wr_cause;
  end

  assert_cause_load_R6: assert property (@(posedge clk) disable iff (rst)
    op_done |=> (cause == $past(op_exc)));
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rm_q) && $stable(dn_q)));
endmodule

// File: rtl/fpu_exc_csr.sv
module fpu_exc_csr
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             op_done,
  input  logic [NEXC:0]    op_exc,
  output logic [CSR_W-1:0] rd_data,
  output logic             trap_req,
  output logic [RM_W-1:0]  rm,
  output logic             dn
);
  logic [NEXC-1:0] wr_flags, wr_enables, flags, enables, set_vec;
  logic [NEXC:0]   wr_cause, cause;
  logic            dn_q;
  logic [RM_W-1:0] rm_q;

  // field extraction from the write word
  for (genvar i = 0; i < NEXC; i++) begin : g_wr
    assign wr_flags[i]   = wr_data[POS_FLAG - i];
    assign wr_enables[i] = wr_data[POS_EN - i];
    assign wr_cause[i]   = wr_data[POS_CAUSE - 1 - i];
  end
  assign wr_cause[IDX_UNIMPL] = wr_data[POS_CAUSE];

  logic unused_wr;
  assign unused_wr = &{1'b0, wr_data[POS_SUM], wr_data[POS_FLAG-NEXC:POS_EN+1],
                       wr_data[POS_EN-NEXC:POS_DN+1]};

  fpx_trap_gate #(.N(NEXC)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .op_done  (op_done),
    .op_exc   (op_exc),
    .enables  (enables),
    .set_vec  (set_vec),
    .trap_req (trap_req)
  );

  fpx_sticky_bank #(.N(NEXC)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_flags (wr_flags),
    .set_vec  (set_vec),
    .flags    (flags)
  );

  fpx_ctrl_regs #(.N(NEXC)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_enables (wr_enables),
    .wr_cause   (wr_cause),
    .wr_dn      (wr_data[POS_DN]),
    .wr_rm      (wr_data[POS_RM +: RM_W]),
    .op_done    (op_done),
    .op_exc     (op_exc),
    .enables    (enables),
    .cause      (cause),
    .dn_q       (dn_q),
    .rm_q       (rm_q)
  );

  // read assembly; summary is derived from stored flags, inexact excluded
  always_comb begin
    rd_data = '0;
    rd_data[POS_SUM] = |flags[NEXC-1:1];
    for (int i = 0; i < NEXC; i++) begin
      rd_data[POS_FLAG - i]      = flags[i];
      rd_data[POS_EN - i]        = enables[i];
      rd_data[POS_CAUSE - 1 - i] = cause[i];
    end
    rd_data[POS_CAUSE]         = cause[IDX_UNIMPL];
    rd_data[POS_DN]            = dn_q;
    rd_data[POS_RM +: RM_W]    = rm_q;
  end

  assign rm = rm_q;
  assign dn = dn_q;

  assert_enabled_no_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (op_done && !wr_en && op_exc[0] && enables[0] && !flags[0]) |=> !flags[0]);
  assert_reset_dn_R1: assert property (@(posedge clk)
    rst |=> (dn && rm == '0 && !trap_req));
endmodule

// File: tb/fpu_exc_csr_tb.sv
module fpu_exc_csr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        op_done;
  logic [5:0]  op_exc;
  logic [31:0] rd_data;
  logic        trap_req;
  logic [1:0]  rm;
  logic        dn;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic [4:0] m_flags, m_en;
  logic [5:0] m_cause;
  logic       m_dn, m_trap;
  logic [1:0] m_rm;

  always #5 clk = ~clk;

  fpu_exc_csr u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_exc(op_exc), .rd_data(rd_data),
    .trap_req(trap_req), .rm(rm), .dn(dn)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[31] = m_flags[1] | m_flags[2] | m_flags[3] | m_flags[4];
    for (int i = 0; i < 5; i++) begin
      w[30-i] = m_flags[i];
      w[14-i] = m_en[i];
      w[6-i]  = m_cause[i];
    end
    w[7]   = m_cause[5];
    w[8]   = m_dn;
    w[1:0] = m_rm;
    return w;
  endfunction

  function automatic void model_step(logic we, logic [31:0] wd, logic od, logic [5:0] ex);
    logic [4:0] setv = od ? (ex[4:0] & ~m_en) : 5'b0;
    m_trap = od && (ex[5] || ((ex[4:0] & m_en) != 0));
    if (we) begin
      for (int i = 0; i < 5; i++) begin
        m_flags[i] = wd[30-i];
        m_en[i]    = wd[14-i];
        m_cause[i] = wd[6-i];
      end
      m_cause[5] = wd[7];
      m_dn = wd[8];
      m_rm = wd[1:0];
    end
    m_flags = m_flags | setv;
    if (od) m_cause = ex;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, rd_data, exp_word());
    chk(req, {31'd0, trap_req}, {31'd0, m_trap});
    chk(req, {30'd0, rm}, {30'd0, m_rm});
    chk(req, {31'd0, dn}, {31'd0, m_dn});
  endtask

  // drive at negedge, let one edge pass, check at the next negedge
  task automatic cyc(logic we, logic [31:0] wd, logic od, logic [5:0] ex, string req);
    wr_en = we; wr_data = wd; op_done = od; op_exc = ex;
    @(posedge clk);
    model_step(we, wd, od, ex);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; wr_data = '0; op_done = 0; op_exc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_flags = '0; m_en = '0; m_cause = '0; m_dn = 1'b1; m_rm = '0; m_trap = 0;
    chk("R1 reset value", rd_data, 32'h0000_0100);
    check_all("R1");

    // all ones: reserved bits stay zero, fields land at fixed positions
    cyc(1, 32'hFFFF_FFFF, 0, 6'h3F, "R2");
    chk("R2 reserved zero", rd_data & 32'h03FF_8200, 32'h0);
    chk("R9 layout", rd_data, 32'hFC00_7DFF);

    cyc(1, 32'h0, 0, 6'h0, "R3 clear by write");
    chk("R3 cleared", rd_data, 32'h0);

    // inexact only: flag set, summary stays 0
    cyc(0, 32'h0, 1, 6'b000001, "R5");
    chk("R5 inexact not in summary", rd_data, 32'h4000_0040);
    cyc(0, 32'h0, 0, 6'h0, "R3 hold");
    chk("R3 hold", rd_data, 32'h4000_0040);

    // underflow masked: summary rises
    cyc(0, 32'h0, 1, 6'b000010, "R5");
    chk("R5 summary", rd_data[31], 1'b1);

    // enable divide by zero only, then raise it: trap and no flag
    cyc(1, 32'h0000_1000, 0, 6'h0, "R4 write enable");
    cyc(0, 32'h0, 1, 6'b000100, "R4");
    chk("R8 trap after enabled", {31'd0, trap_req}, 32'd1);
    chk("R4 no flag", {31'd0, rd_data[28]}, 32'd0);
    cyc(0, 32'h0, 0, 6'h0, "R8 pulse ends");
    chk("R8 trap single cycle", {31'd0, trap_req}, 32'd0);

    // unimplemented with nothing enabled
    cyc(1, 32'h0, 0, 6'h0, "R6");
    cyc(0, 32'h0, 1, 6'b100000, "R6");
    chk("R6 unimpl traps", {31'd0, trap_req}, 32'd1);
    chk("R6 cause", rd_data, 32'h0000_0080);

    // clearing write and masked overflow in one cycle
    cyc(1, 32'h0, 1, 6'b001000, "R7");
    chk("R7 merge", rd_data, 32'h8800_0008);

    // exceptions ignored without op_done
    cyc(0, 32'h0, 0, 6'h3F, "R8 ignored");
    chk("R8 ignored", rd_data, 32'h8800_0008);

    cyc(1, 32'h0000_0003, 0, 6'h0, "R9");
    chk("R9 rm", {30'd0, rm}, 32'd3);
    chk("R9 dn cleared", {31'd0, dn}, 32'd0);

    for (int k = 0; k < 3000; k++) begin
      logic we = ($urandom % 8) == 0;
      logic od = ($urandom % 2) == 0;
      logic [5:0] ex = $urandom;
      if (($urandom % 4) != 0) ex[5] = 1'b0;
      cyc(we, $urandom, od, ex, "R3 R4 R6 R7 R8 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule